// File: doc/BRIEF.md
# Address Security Attribute Lookup Unit

This block gives the processor a fixed security attribution for any address it presents. The answer comes back in the same cycle and needs no table walk. The top four address bits select one of sixteen regions. The block returns four things for the address:

- the region number;
- whether the address is non-secure;
- whether it lies in a secure window that non-secure code may call into (non-secure-callable);
- whether it falls in one of the two debug windows that are exempt from checking.

Software controls the non-secure-callable status through a two-bit enable register, one bit per callable window. The register is written and read over a plain write-enable/data port. The lookup itself is purely combinational from the address and the registered enables. Everything the block returns is derived from fixed address bits and the enable register. The processor's own attribution may therefore only be made stricter by this unit, never looser.

Top module: `sec_attr_unit`

## Requirements
- R1: `region_id` always equals address bits [31:28].
- R2: `is_ns` is 1 exactly when address bit 28 is 0, so regions with an even number are non-secure and regions with an odd number are secure.
- R3: `is_nsc` is 1 only in two cases: region 1 while enable bit 0 is set, and region 3 while enable bit 1 is set. Every other region/enable combination gives 0.
- R4: `is_exempt` is 1 exactly when address bits [31:20] equal 0xE00 or 0xF00. Both windows are one megabyte, from 0xE000_0000 to 0xE00F_FFFF and from 0xF000_0000 to 0xF00F_FFFF.
- R5: A rising clock edge with `rst_n` low (synchronous, active low) clears the enable register to 0.
- R6: A rising edge with `cfg_we` high stores `cfg_wdata[1:0]` into the enable register. Bits above bit 1 are ignored.
- R7: `cfg_rdata` presents the two enable bits in bits [1:0], and zeros in all bits above them.
- R8: A lookup made in the same cycle as an enable write uses the old enables. The new value affects lookups from the cycle after the write edge, and the register holds its value while `cfg_we` is low.
- R9: `is_nsc` is never 1 while `is_ns` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 32 | Enable register write data; only [1:0] used |
| cfg_rdata | output | 32 | Enable register read data |
| lookup_addr | input | 32 | Address being attributed |
| region_id | output | 4 | Region number of the address |
| is_ns | output | 1 | Address is non-secure |
| is_nsc | output | 1 | Address is secure and non-secure-callable |
| is_exempt | output | 1 | Address lies in an exempt debug window |

## Verification
Two things can happen in the same cycle: an enable write and a lookup that depends on the enable being written. The bench holds an address in region 1 and raises the write strobe at the falling edge. It then confirms that `is_nsc` still reflects the old enable until the rising edge has passed, and that it takes the new value afterwards. Around this case, every region is swept under every enable value, with upper write-data bits set to nonzero values. The edges of both exempt windows are also probed.

// File: rtl/sec_attr_pkg.sv
package sec_attr_pkg;
    localparam int REGION_W    = 4;
    localparam int NSC_WINDOWS = 2;

    typedef struct packed {
        logic [REGION_W-1:0] region;
        logic                ns;
        logic                nsc;
        logic                exempt;
    } attr_t;

    typedef struct packed {
        logic [NSC_WINDOWS-1:0] nsc_en;
    } cfg_state_t;
endpackage

// File: rtl/sec_attr_cfg.sv
module sec_attr_cfg
    import sec_attr_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [REG_W-1:0]       wdata,
    output logic [REG_W-1:0]       rdata,
    output logic [NSC_WINDOWS-1:0] nsc_en
);
    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.nsc_en = wdata[NSC_WINDOWS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign nsc_en = state_q.nsc_en;
    assign rdata  = {{(REG_W-NSC_WINDOWS){1'b0}}, state_q.nsc_en};

    // R5: register is cleared after a reset edge
    assert_cfg_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (state_q.nsc_en == '0));

    // R6: write captures the low bits of the data
    assert_cfg_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we)) |-> (nsc_en == $past(wdata[NSC_WINDOWS-1:0])));

    // R8: no write, no change
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(we)) |-> $stable(nsc_en));
endmodule

// File: rtl/sec_attr_lookup.sv
module sec_attr_lookup
    import sec_attr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NSC_WINDOWS-1:0] nsc_en,
    output attr_t                  attr
);
    localparam int RID_LSB = ADDR_W - REGION_W;
    localparam int EX_W    = 12;
    localparam int EX_LSB  = ADDR_W - EX_W;
    localparam logic [EX_W-1:0] EX_MASK  = 12'hEFF;
    localparam logic [EX_W-1:0] EX_MATCH = 12'hE00;

    logic [REGION_W-1:0]    rid;
    logic [NSC_WINDOWS-1:0] win_hit;

    assign rid = addr[ADDR_W-1:RID_LSB];

    for (genvar w = 0; w < NSC_WINDOWS; w++) begin : g_nsc_win
        localparam logic [REGION_W-1:0] WIN_RID = REGION_W'(2 * w + 1);
        assign win_hit[w] = (rid == WIN_RID) && nsc_en[w];
    end

    always_comb begin
        attr.region = rid;
        attr.ns     = ~rid[0];
        attr.nsc    = |win_hit;
        attr.exempt = ((addr[ADDR_W-1:EX_LSB] & EX_MASK) == EX_MATCH);
    end
endmodule

// File: rtl/sec_attr_unit.sv
module sec_attr_unit
    import sec_attr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    input  logic [ADDR_W-1:0]   lookup_addr,
    output logic [REGION_W-1:0] region_id,
    output logic                is_ns,
    output logic                is_nsc,
    output logic                is_exempt
);
    logic [NSC_WINDOWS-1:0] nsc_en;
    attr_t                  attr;

    sec_attr_cfg #(.REG_W(REG_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .nsc_en (nsc_en)
    );

    sec_attr_lookup #(.ADDR_W(ADDR_W)) u_lookup (
        .addr   (lookup_addr),
        .nsc_en (nsc_en),
        .attr   (attr)
    );

    assign region_id = attr.region;
    assign is_ns     = attr.ns;
    assign is_nsc    = attr.nsc;
    assign is_exempt = attr.exempt;

    // R9: callable only in secure regions
    assert_nsc_secure_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_nsc |-> !is_ns);

    // R3: callable only in regions 1 and 3
    assert_nsc_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_nsc |-> (region_id == 4'd1 || region_id == 4'd3));

    // R4: exempt windows sit in regions 14 and 15
    assert_exempt_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_exempt |-> (region_id[3:1] == 3'b111));

    // R7: read data has zeros above the enable bits
    assert_rdata_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[REG_W-1:NSC_WINDOWS] == '0);
endmodule

// File: tb/sec_attr_unit_tb.sv
module sec_attr_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] lookup_addr = '0;
    logic [3:0]  region_id;
    logic        is_ns, is_nsc, is_exempt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_attr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .lookup_addr(lookup_addr), .region_id(region_id),
        .is_ns(is_ns), .is_nsc(is_nsc), .is_exempt(is_exempt)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = 32'hFFFF_FFFC;
    endtask

    task automatic probe(input logic [31:0] a, input logic [1:0] cfg);
        logic [3:0] r;
        lookup_addr = a;
        #1;
        r = a[31:28];
        chk("R1", "region", {28'd0, region_id}, {28'd0, r});
        chk("R2", "ns", {31'd0, is_ns}, {31'd0, (r % 2 == 0)});
        chk("R3", "nsc", {31'd0, is_nsc},
            {31'd0, ((r == 1 && cfg[0]) || (r == 3 && cfg[1]))});
        chk("R9", "nsc_vs_ns", {31'd0, is_nsc && is_ns}, 32'd0);
        chk("R4", "exempt", {31'd0, is_exempt},
            {31'd0, (a[31:20] == 12'hE00 || a[31:20] == 12'hF00)});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R5", "reset rdata", cfg_rdata, 32'd0);
        probe(32'h1000_0000, 2'b00);

        for (int c = 0; c < 4; c++) begin
            write_cfg({30'h2AAA_AAA5 ^ 30'(c), 2'(c)});
            #1;
            chk("R6", "stored cfg", cfg_rdata, 32'(c));
            chk("R7", "rdata upper zero", cfg_rdata & 32'hFFFF_FFFC, 32'd0);
            for (int r = 0; r < 16; r++) begin
                probe({4'(r), 28'h0ABC_DE5}, 2'(c));
            end
        end

        probe(32'hE000_0000, 2'b11);
        probe(32'hE00F_FFFF, 2'b11);
        probe(32'hE010_0000, 2'b11);
        probe(32'hDFFF_FFFF, 2'b11);
        probe(32'hF000_0000, 2'b11);
        probe(32'hF00F_FFFF, 2'b11);
        probe(32'hF010_0000, 2'b11);
        probe(32'hEFFF_FFFF, 2'b11);

        // R8: write and lookup in the same cycle
        write_cfg(32'd0);
        lookup_addr = 32'h1234_5678;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = 32'hFFFF_FFFD;
        #1;
        chk("R8", "nsc before edge", {31'd0, is_nsc}, 32'd0);
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        chk("R8", "nsc after edge", {31'd0, is_nsc}, 32'd1);
        repeat (3) @(posedge clk);
        #1;
        chk("R8", "hold without write", cfg_rdata, 32'd1);

        // R5: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R5", "mid-run reset", cfg_rdata, 32'd0);
        chk("R5", "nsc after reset", {31'd0, is_nsc}, 32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule